// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Read Controller

This controller sits between a cache and a main memory split into several banks, with words spread across the banks one after another. Word address `a` lives in bank `a mod NB` at row `a / NB`. A line fill covers `NB` consecutive words. It uses one address phase that starts every bank at once, so all bank accesses overlap. After that, the words come back one at a time over a single one-word return bus, bank 0 first. With the default timing (4 address cycles, 56 access cycles, 4 transfer cycles, 4 banks), a line fill takes 76 cycles. Fetching the same four words one after another would take 256.

The controller also accepts single-word requests at up to one per cycle. Each one starts only its own bank, and the word comes back after a fixed access latency. Each bank has a down-counter that marks it busy for the length of one access. A request aimed at a busy bank is held off with `req_ready` low until that bank can take a new access. A sequential stream therefore runs without stalls only when the bank count is at least the access time in cycles.

The banks themselves sit outside the block. The controller sends them one start strobe per bank and a shared row address. Each bank must hold its word steady from the cycle after its start strobe until its next start. `T_ACC` must be at least 2.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: A single-word request for address `a` is served by bank `a mod NB`. The data returned is that bank's word at row `a / NB`. The start strobe and row for the request appear on `bank_start`/`bank_row` in the cycle after acceptance.
- R2: A line request ignores the low `log2(NB)` address bits. It returns the words at base, base+1, …, base+NB-1 in that order, where base is the address with those bits cleared. Word k comes from bank k.
- R3: For a line request accepted at edge n, word k (k = 0…NB-1) is presented with `rsp_valid` high for exactly the one cycle following edge n + T_ADDR + T_ACC + (k+1)·T_XFER. With the defaults, the last word follows edge n+76.
- R4: For a line request accepted at edge n, the cycle following edge n + T_ADDR shows every bit of `bank_start` high and `bank_row` equal to base / NB.
- R5: `rsp_last` is high only together with the final word of a line fill. Single-word responses have `rsp_last` low.
- R6: `req_ready` is low from the acceptance of a line request until the edge that presents its last word. The earliest next acceptance is edge n + T_ADDR + T_ACC + NB·T_XFER + 1.
- R7: A single-word request accepted at edge n returns its word with `rsp_valid` high for the one cycle following edge n + T_ACC. Exactly one bit of `bank_start` is set in the cycle after acceptance.
- R8: Single-word requests to different idle banks are accepted on consecutive edges. A request to a bank whose access started at edge m is held off with `req_ready` low and is accepted no earlier than edge m + T_ACC.
- R9: A line request is held off until every bank can start a new access. If the most recent bank access started at edge m, the line is accepted no earlier than edge m + T_ACC.
- R10: While `rst` is high at a clock edge, the cycle after shows `req_ready` high, and `rsp_valid`, `rsp_last` and `bank_start` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_line | input | 1 | 1: line fill of NB words, 0: single word |
| req_addr | input | AW | Word address |
| rsp_valid | output | 1 | Returned word valid (one-cycle pulse) |
| rsp_last | output | 1 | Final word of a line fill |
| rsp_data | output | W | Returned word |
| bank_start | output | NB | One-cycle start strobe per bank |
| bank_row | output | AW-log2(NB) | Row address for the banks being started |
| bank_rdata | input | NB·W | Word held by each bank, bank b in bits b·W upward |

## Verification
Suppose a bank countdown is off by one, or loaded at the wrong moment. The ports then show this on the very next request to that bank: it is accepted a cycle early or late, and its word comes back off the expected edge. The scoreboard compares the arrival edge of every word exactly, as well as its data. A bad bank or row mapping gives a data mismatch on the first response of the affected word. A broken fill sequencer shifts the last flag or the word order within the 76-cycle window of the first line fill.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ADDR,
    FS_ACC,
    FS_XFER
  } fill_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
  parameter int unsigned T_ACC = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic free,
  output logic done
);
  localparam int unsigned CW = $clog2(T_ACC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(T_ACC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // the final busy cycle also counts as free so a new access can overlap the hand-off
  assign free = (cnt <= CW'(1));
  assign done = (cnt == CW'(1));

endmodule

// File: rtl/ilv_fill_seq.sv
module ilv_fill_seq
  import ilv_pkg::*;
#(
  parameter int unsigned NB     = 4,
  parameter int unsigned T_ADDR = 4,
  parameter int unsigned T_ACC  = 56,
  parameter int unsigned T_XFER = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  active,
  output logic                  issue,
  output logic                  fire,
  output logic                  fire_last,
  output logic [$clog2(NB)-1:0] fire_idx
);
  localparam int unsigned LB = $clog2(NB);
  localparam int unsigned PW = $clog2(max3(T_ADDR, T_ACC, T_XFER) + 1);

  fill_state_e   state;
  logic [PW-1:0] ph;
  logic [LB-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FS_IDLE;
      ph    <= '0;
      idx   <= '0;
    end else begin
      case (state)
        FS_IDLE: begin
          if (start) begin
            state <= FS_ADDR;
            ph    <= PW'(T_ADDR - 1);
          end
        end
        FS_ADDR: begin
          if (ph == '0) begin
            state <= FS_ACC;
            ph    <= PW'(T_ACC - 1);
          end else begin
            ph <= ph - 1'b1;
          end
        end
        FS_ACC: begin
          if (ph == '0) begin
            state <= FS_XFER;
            ph    <= PW'(T_XFER - 1);
            idx   <= '0;
          end else begin
            ph <= ph - 1'b1;
          end
        end
        FS_XFER: begin
          if (ph == '0) begin
            ph <= PW'(T_XFER - 1);
            if (idx == LB'(NB - 1)) begin
              state <= FS_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            ph <= ph - 1'b1;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign active    = (state != FS_IDLE);
  assign issue     = (state == FS_ADDR) && (ph == '0);
  assign fire      = (state == FS_XFER) && (ph == '0);
  assign fire_last = fire && (idx == LB'(NB - 1));
  assign fire_idx  = idx;

endmodule

// File: rtl/ilv_ret_stage.sv
module ilv_ret_stage #(
  parameter int unsigned NB = 4,
  parameter int unsigned W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  logic                  fire_last,
  input  logic [$clog2(NB)-1:0] fire_idx,
  input  logic [NB-1:0]         strm_hit,
  input  logic [NB*W-1:0]       bank_rdata,
  output logic                  rsp_valid,
  output logic                  rsp_last,
  output logic [W-1:0]          rsp_data
);
  logic [W-1:0] hit_word;
  logic [W-1:0] nxt_word;

  // stream completions are one-hot: accepts happen one per cycle with equal latency
  always_comb begin
    hit_word = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (strm_hit[b]) hit_word = hit_word | bank_rdata[b*W +: W];
    end
  end

  assign nxt_word = fire ? bank_rdata[fire_idx*W +: W] : hit_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire | (|strm_hit);
      rsp_last  <= fire_last;
      if (fire | (|strm_hit)) rsp_data <= nxt_word;
    end
  end

endmodule

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
  parameter int unsigned NB     = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned W      = 32,
  parameter int unsigned T_ADDR = 4,
  parameter int unsigned T_ACC  = 56,
  parameter int unsigned T_XFER = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_line,
  input  logic [AW-1:0]              req_addr,
  output logic                       rsp_valid,
  output logic                       rsp_last,
  output logic [W-1:0]               rsp_data,
  output logic [NB-1:0]              bank_start,
  output logic [AW-$clog2(NB)-1:0]   bank_row,
  input  logic [NB*W-1:0]            bank_rdata
);
  localparam int unsigned LB = $clog2(NB);
  localparam int unsigned RW = AW - LB;

  logic [LB-1:0] tgt;
  logic [RW-1:0] req_row;
  logic [RW-1:0] line_row;
  logic [NB-1:0] bank_free;
  logic [NB-1:0] bank_done;
  logic [NB-1:0] bank_load;
  logic [NB-1:0] strm_flag;
  logic          fill_active;
  logic          fill_issue;
  logic          xfer_fire;
  logic          xfer_last;
  logic [LB-1:0] xfer_idx;
  logic          acc_word;
  logic          acc_line;

  assign tgt     = req_addr[LB-1:0];
  assign req_row = req_addr[AW-1:LB];

  assign req_ready = !fill_active && (req_line ? (&bank_free) : bank_free[tgt]);
  assign acc_word  = req_valid && req_ready && !req_line;
  assign acc_line  = req_valid && req_ready && req_line;

  for (genvar g = 0; g < int'(NB); g++) begin : g_bank
    assign bank_load[g] = (acc_word && (tgt == LB'(g))) || fill_issue;

    ilv_bank_timer #(.T_ACC(T_ACC)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .load (bank_load[g]),
      .free (bank_free[g]),
      .done (bank_done[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        strm_flag[g] <= 1'b0;
      end else if (acc_word && (tgt == LB'(g))) begin
        strm_flag[g] <= 1'b1;
      end else if (bank_done[g]) begin
        strm_flag[g] <= 1'b0;
      end
    end
  end

  ilv_fill_seq #(
    .NB(NB), .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (acc_line),
    .active    (fill_active),
    .issue     (fill_issue),
    .fire      (xfer_fire),
    .fire_last (xfer_last),
    .fire_idx  (xfer_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_row   <= '0;
      bank_row   <= '0;
      bank_start <= '0;
    end else begin
      if (acc_line) line_row <= req_row;
      if (fill_issue) begin
        bank_start <= '1;
        bank_row   <= line_row;
      end else if (acc_word) begin
        bank_start <= NB'(1) << tgt;
        bank_row   <= req_row;
      end else begin
        bank_start <= '0;
      end
    end
  end

  ilv_ret_stage #(.NB(NB), .W(W)) u_ret (
    .clk        (clk),
    .rst        (rst),
    .fire       (xfer_fire),
    .fire_last  (xfer_last),
    .fire_idx   (xfer_idx),
    .strm_hit   (bank_done & strm_flag),
    .bank_rdata (bank_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_last   (rsp_last),
    .rsp_data   (rsp_data)
  );

endmodule

// File: rtl/ilv_bank_ctrl_chk.sv
module ilv_bank_ctrl_chk #(
  parameter int unsigned NB     = 4,
  parameter int unsigned T_ADDR = 4,
  parameter int unsigned T_ACC  = 56,
  parameter int unsigned T_XFER = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_line,
  input logic          rsp_valid,
  input logic          rsp_last,
  input logic [NB-1:0] bank_start
);
  localparam int unsigned FILL_LAT = T_ADDR + T_ACC + NB * T_XFER;

  logic        fill_on;
  logic [31:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_on  <= 1'b0;
      fill_cnt <= '0;
    end else if (req_valid && req_ready && req_line) begin
      fill_on  <= 1'b1;
      fill_cnt <= '0;
    end else if (rsp_last) begin
      fill_on <= 1'b0;
    end else if (fill_on) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  // R5
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);

  // R3
  a_r3_fill_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> (fill_on && fill_cnt == 32'(FILL_LAT)));

  // R6
  a_r6_hold_during_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_on && !rsp_last) |-> !req_ready);

  // R4
  a_r4_fill_start_all: assert property (@(posedge clk) disable iff (rst)
    (fill_on && fill_cnt == 32'(T_ADDR)) |-> (bank_start == {NB{1'b1}}));

  // R7
  a_r7_word_start_single: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_line) |=> ($countones(bank_start) == 1));

  // R4 R7
  a_r4_start_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(bank_start) <= 1) || (bank_start == {NB{1'b1}}));

endmodule

bind ilv_bank_ctrl ilv_bank_ctrl_chk #(
  .NB(NB), .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_line   (req_line),
  .rsp_valid  (rsp_valid),
  .rsp_last   (rsp_last),
  .bank_start (bank_start)
);

// File: tb/ilv_bank_ctrl_bench.sv
module ilv_bank_ctrl_bench;
  localparam int NB       = 4;
  localparam int AW       = 16;
  localparam int W        = 32;
  localparam int T_ADDR   = 4;
  localparam int T_ACC    = 56;
  localparam int T_XFER   = 4;
  localparam int LB       = $clog2(NB);
  localparam int FILL_LAT = T_ADDR + T_ACC + NB * T_XFER;
  localparam int WDOG     = 5000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid;
  logic              req_ready;
  logic              req_line;
  logic [AW-1:0]     req_addr;
  logic              rsp_valid;
  logic              rsp_last;
  logic [W-1:0]      rsp_data;
  logic [NB-1:0]     bank_start;
  logic [AW-LB-1:0]  bank_row;
  logic [NB*W-1:0]   bank_rdata;

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [W-1:0] data;
    bit           last;
    int           when;
    string        tag;
  } exp_t;

  exp_t sbq[$];

  function automatic logic [W-1:0] word_of(input int unsigned a);
    return (a * 32'h9E37_79B1) ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  ilv_bank_ctrl #(
    .NB(NB), .AW(AW), .W(W), .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER)
  ) u_ilv_bank_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_line   (req_line),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_last   (rsp_last),
    .rsp_data   (rsp_data),
    .bank_start (bank_start),
    .bank_row   (bank_row),
    .bank_rdata (bank_rdata)
  );

  // behavioural banks: latch the row on start, hold the word until the next start
  logic [AW-LB-1:0] lat_row [NB];

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (rst) lat_row[b] <= '0;
      else if (bank_start[b]) lat_row[b] <= bank_row;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bank_rdata[b*W +: W] = word_of(int'(lat_row[b]) * NB + b);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R3 R7", "unexpected response data", rsp_data, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
        chk(rsp_last == e.last, e.tag, "last flag", rsp_last, e.last);
        chk(cyc == e.when, e.tag, "arrival edge", cyc, e.when);
      end
    end
  end

  task automatic send(input int addr, input bit line, output int acc);
    int base;
    @(negedge clk);
    req_valid = 1'b1;
    req_line  = line;
    req_addr  = AW'(addr);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    if (line) begin
      base = addr & ~(NB - 1);
      for (int k = 0; k < NB; k++) begin
        sbq.push_back('{word_of(base + k), (k == NB - 1),
                        acc + T_ADDR + T_ACC + (k + 1) * T_XFER, "R2 R3 R5"});
      end
    end else begin
      sbq.push_back('{word_of(addr), 1'b0, acc + T_ACC, "R1 R5 R7"});
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    wait (cyc >= WDOG);
    chk(1'b0, "R3", "watchdog expired at cycle", cyc, WDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a_l1, a_l2, a_l3, a_l4;
    int a_s [6];
    int a_x;

    req_valid = 1'b0;
    req_line  = 1'b0;
    req_addr  = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", rsp_valid, 0);
    chk(rsp_last == 1'b0, "R10", "rsp_last in reset", rsp_last, 0);
    chk(bank_start == '0, "R10", "bank_start in reset", bank_start, 0);
    rst = 1'b0;

    // aligned line fill
    send(32'h20, 1'b1, a_l1);
    do @(negedge clk); while (cyc != a_l1 + T_ADDR);
    chk(bank_start == {NB{1'b1}}, "R4", "all-bank start", bank_start, {NB{1'b1}});
    chk(bank_row == (32'h20 >> LB), "R4", "line row", bank_row, 32'h20 >> LB);
    chk(req_ready == 1'b0, "R6", "ready during fill", req_ready, 0);

    // unaligned line right behind it: low bits dropped, waits for the first fill
    send(32'h47, 1'b1, a_l2);
    chk(a_l2 == a_l1 + FILL_LAT + 1, "R6", "next accept after fill", a_l2, a_l1 + FILL_LAT + 1);

    // sequential stream across all banks, then wrapping back onto busy banks
    for (int i = 0; i < 6; i++) send(32'h100 + i, 1'b0, a_s[i]);
    for (int i = 1; i < NB; i++)
      chk(a_s[i] == a_s[i-1] + 1, "R8", "back-to-back accept", a_s[i], a_s[i-1] + 1);
    chk(a_s[4] == a_s[0] + T_ACC, "R8", "bank 0 conflict stall", a_s[4], a_s[0] + T_ACC);
    chk(a_s[5] == a_s[1] + T_ACC, "R8", "bank 1 conflict stall", a_s[5], a_s[1] + T_ACC);

    // line request must wait for every bank
    send(32'h200, 1'b1, a_l3);
    chk(a_l3 == a_s[5] + T_ACC, "R9", "line waits for busy banks", a_l3, a_s[5] + T_ACC);

    // single word after a fill: strobe shape and row mapping
    send(32'h301, 1'b0, a_x);
    chk(a_x == a_l3 + FILL_LAT + 1, "R6", "word after fill", a_x, a_l3 + FILL_LAT + 1);
    @(negedge clk);
    chk(cyc == a_x, "R7", "strobe sample edge", cyc, a_x);
    chk(bank_start == NB'(2), "R1 R7", "single strobe for bank 1", bank_start, 2);
    chk(bank_row == (32'h301 >> LB), "R1", "word row", bank_row, 32'h301 >> LB);

    // line at the top of the address range
    send(32'hFFFE, 1'b1, a_l4);
    chk(a_l4 == a_x + T_ACC, "R9", "line waits for word access", a_l4, a_x + T_ACC);

    repeat (FILL_LAT + 4) @(negedge clk);
    chk(sbq.size() == 0, "R3 R7", "responses outstanding", sbq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule